// File: doc/BRIEF.md
# Dual-Role SPI Port with Frame Timing Control

This block is a synchronous serial port that can act either as the clock-generating side (master) or the clock-following side (slave) of an SPI link. A single control bit picks the role. Clock polarity, clock phase, bit order and frame length (8 or 16 bits) mean the same thing in both roles. Words are moved through two small FIFOs, one for each direction, and a register-style host port with four word addresses.

As master, the port runs a frame whenever the transmit FIFO holds a word. It lowers its select output, waits a programmable lead time, runs the serial clock from a programmable divider, waits a programmable lag time after the last clock edge, raises select and then keeps a programmable quiet gap before the next frame. As slave, it starts a frame when its select input falls. It shifts out the head of the transmit FIFO on the clock it receives, and it ignores the divider and the three delays.

Top module: `spi_port`

## Requirements
- R1: Register 0 (CTRL) holds the role and format: bit0 = 1 selects master and 0 selects slave, bit1 CPOL, bit2 CPHA, bit3 = 1 sends LSB first, bit4 = 1 selects 16-bit frames. In slave mode `ssn_o` stays 1 and `sck_o` rests at CPOL.
- R2: After reset, STATUS reads 0x0014 (both FIFOs empty, not busy), `ssn_o` is 1 and `sck_o` is 0.
- R3: In master mode, writing a word to register 2 (DATA) queues it and starts a frame. With CPHA=0, data is sampled on the leading clock edge and changes on the trailing edge. With CPHA=1, it changes on the leading edge and is sampled on the trailing edge. The word sampled from `sdi` is pushed into the receive FIFO.
- R4: With CTRL bit3 = 0 the highest frame bit leaves first. With bit3 = 1 bit 0 leaves first. Received words are put together in the same order.
- R5: An 8-bit frame has 8 clock cycles (16 edges) and a 16-bit frame has 16 (32 edges). An 8-bit received word reads back with bits 15:8 at zero.
- R6: Register 1 (TIMING) holds div in bits 3:0, lead in 6:4, lag in 9:7 and gap in 12:10. Half a serial clock lasts div+1 clk cycles. With H(v) = 2v for v > 0 and H(0) = 1, the first clock edge comes H(lead)*(div+1) clk cycles after `ssn_o` falls.
- R7: `ssn_o` rises H(lag)*(div+1) clk cycles after the last clock edge of a frame.
- R8: Between the rise of `ssn_o` and its next fall there are at least H(gap)*(div+1) clk cycles.
- R9: In slave mode, a fall of `ssn_i` starts a frame. The port shifts out the transmit FIFO head on `sdo` and captures `sdi` into the receive FIFO under the same edge rules, whatever TIMING holds.
- R10: STATUS (register 3) bits: 0 busy, 1 tx full, 2 tx empty, 3 rx full, 4 rx empty, 5 overrun. A DATA write while the transmit FIFO is full is dropped. Reading DATA pops the receive FIFO. Both FIFOs are 4 words deep.
- R11: A frame that completes while the receive FIFO is full discards its word and sets STATUS bit5. Writing 1 to bit5 of register 3 clears the flag.
- R12: While `ssn_o` is high, `sck_o` sits at the CPOL level.
- R13: A slave frame that starts with an empty transmit FIFO sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (pops receive FIFO at address 2) |
| addr | input | 2 | Host register address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data for `addr` |
| sck_o | output | 1 | Serial clock driven in master mode |
| ssn_o | output | 1 | Active-low select driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ssn_i | input | 1 | Active-low select received in slave mode |
| sdi | input | 1 | Serial data in (master in / slave in) |
| sdo | output | 1 | Serial data out (master out / slave out) |

## Verification
A wrong edge counter shows up within one frame as a wrong edge count, or as a received word that does not match the one sent back through the loop. A wrong bit pointer or a wrong sample/drive choice corrupts the serial bit sequence that the bench captures on the sample edges. A wrong delay count appears as an exact cycle mismatch between the select and clock transitions of the first frame. A wrong FIFO pointer or count appears a few host accesses later, as bad flags or as words read back out of order.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {PH_IDLE, PH_LEAD, PH_XFER, PH_LAG, PH_GAP} phase_e;

    // CTRL layout, bit0 first: role, polarity, phase, order, width
    typedef struct packed {
        logic wide;
        logic lsb_first;
        logic cpha;
        logic cpol;
        logic master;
    } mode_cfg_t;

    // TIMING layout: div[3:0], lead[6:4], lag[9:7], gap[12:10]
    typedef struct packed {
        logic [2:0] spare;
        logic [2:0] gap;
        logic [2:0] lag;
        logic [2:0] lead;
        logic [3:0] div;
    } time_cfg_t;

    // delay setting -> number of half serial-clock periods
    function automatic logic [3:0] half_periods(input logic [2:0] v);
        return (v == 3'd0) ? 4'd1 : {v, 1'b0};
    endfunction

    function automatic logic first_bit(input logic [WORD_W-1:0] w, input mode_cfg_t m);
        return m.lsb_first ? w[0] : (m.wide ? w[15] : w[7]);
    endfunction

    function automatic logic [WORD_W-1:0] advance(input logic [WORD_W-1:0] w, input mode_cfg_t m);
        return m.lsb_first ? (w >> 1) : (w << 1);
    endfunction

    function automatic logic [WORD_W-1:0] take_bit(input logic [WORD_W-1:0] w, input logic b,
                                                   input mode_cfg_t m);
        if (!m.lsb_first) return {w[WORD_W-2:0], b};
        if (m.wide)       return {b, w[WORD_W-1:1]};
        return {8'h00, b, w[7:1]};
    endfunction

endpackage

// File: rtl/spi_port_fifo.sv
module spi_port_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign dout  = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp        = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && q.cnt == $past(q.cnt)));

    // R10
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mode_cfg_t         mode,
    input  time_cfg_t         tcfg,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              ovr_set,
    output logic              busy,
    output logic              sck_o,
    output logic              ssn_o,
    output logic              sdo,
    input  logic              sck_i,
    input  logic              ssn_i,
    input  logic              sdi
);
    typedef struct packed {
        phase_e            ph;
        logic [3:0]        hcnt;
        logic [3:0]        dcnt;
        logic [5:0]        ecnt;
        logic [WORD_W-1:0] txs;
        logic [WORD_W-1:0] rxs;
        logic              sck;
        logic              ssn;
        logic              dout;
        logic [2:0]        sck_sy;
        logic [2:0]        ssn_sy;
        logic [1:0]        sdi_sy;
    } eng_st_t;

    eng_st_t q, d;
    logic       tick, load, edge_ev, leading, sample, sin;
    logic [5:0] last_edge;

    assign sck_o = q.sck;
    assign ssn_o = q.ssn;
    assign sdo   = q.dout;

    always_comb begin
        d         = q;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        ovr_set   = 1'b0;
        load      = 1'b0;
        edge_ev   = 1'b0;
        d.sck_sy  = {q.sck_sy[1:0], sck_i};
        d.ssn_sy  = {q.ssn_sy[1:0], ssn_i};
        d.sdi_sy  = {q.sdi_sy[0], sdi};
        last_edge = mode.wide ? 6'd31 : 6'd15;
        tick      = (q.hcnt == tcfg.div);

        if (mode.master) begin
            sin    = sdi;
            busy   = (q.ph != PH_IDLE);
            d.hcnt = (q.ph == PH_IDLE || tick) ? 4'd0 : q.hcnt + 4'd1;
            case (q.ph)
                PH_IDLE: begin
                    d.sck = mode.cpol;
                    d.ssn = 1'b1;
                    if (!tx_empty) begin
                        load   = 1'b1;
                        d.ph   = PH_LEAD;
                        d.ssn  = 1'b0;
                        d.dcnt = half_periods(tcfg.lead);
                    end
                end
                PH_LEAD: if (tick) begin
                    if (q.dcnt == 4'd1) begin
                        edge_ev = 1'b1;
                        d.ph    = PH_XFER;
                    end else d.dcnt = q.dcnt - 4'd1;
                end
                PH_XFER: edge_ev = tick;
                PH_LAG: if (tick) begin
                    if (q.dcnt == 4'd1) begin
                        d.ssn  = 1'b1;
                        d.ph   = PH_GAP;
                        d.dcnt = half_periods(tcfg.gap);
                    end else d.dcnt = q.dcnt - 4'd1;
                end
                PH_GAP: if (tick) begin
                    if (q.dcnt == 4'd1) d.ph = PH_IDLE;
                    else                d.dcnt = q.dcnt - 4'd1;
                end
                default: d.ph = PH_IDLE;
            endcase
        end else begin
            sin    = q.sdi_sy[1];
            busy   = !q.ssn_sy[1];
            d.ph   = PH_IDLE;
            d.hcnt = 4'd0;
            d.ssn  = 1'b1;
            d.sck  = mode.cpol;
            if (q.ssn_sy[2] && !q.ssn_sy[1])
                load = 1'b1;
            else if (!q.ssn_sy[1] && (q.sck_sy[1] != q.sck_sy[2]) && q.ecnt <= last_edge)
                edge_ev = 1'b1;
        end

        if (load) begin
            tx_pop = !tx_empty;
            d.ecnt = 6'd0;
            d.rxs  = '0;
            d.txs  = tx_empty ? '0 : tx_data;
            if (!mode.cpha) begin
                d.dout = first_bit(d.txs, mode);
                d.txs  = advance(d.txs, mode);
            end
        end

        leading = !q.ecnt[0];
        sample  = leading ^ mode.cpha;
        if (edge_ev) begin
            d.ecnt = q.ecnt + 6'd1;
            if (mode.master) d.sck = ~q.sck;
            if (sample) d.rxs = take_bit(q.rxs, sin, mode);
            else if (q.ecnt != last_edge) begin
                d.dout = first_bit(q.txs, mode);
                d.txs  = advance(q.txs, mode);
            end
            if (q.ecnt == last_edge) begin
                rx_push = !rx_full;
                ovr_set = rx_full;
                if (mode.master) begin
                    d.ph   = PH_LAG;
                    d.dcnt = half_periods(tcfg.lag);
                end
            end
        end
        rx_data = mode.wide ? d.rxs : {8'h00, d.rxs[7:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ssn    <= 1'b1;
            q.ssn_sy <= 3'b111;
        end else begin
            q <= d;
        end
    end

    // R1
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.master && !$past(mode.master)) |-> ssn_o);

    // R12
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ssn_o && $stable(mode.cpol) && $past(ssn_o)) |-> (sck_o == mode.cpol));

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        sck_o,
    output logic        ssn_o,
    input  logic        sck_i,
    input  logic        ssn_i,
    input  logic        sdi,
    output logic        sdo
);
    typedef struct packed {
        mode_cfg_t mode;
        time_cfg_t tcfg;
        logic      ovr;
    } regs_t;

    regs_t q, d;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic              ovr_set, busy;
    logic [WORD_W-1:0] tx_head, rx_word, rx_head;

    assign tx_push = wr_en && addr == 2'd2;
    assign rx_pop  = rd_en && addr == 2'd2;

    always_comb begin
        d = q;
        if (wr_en && addr == 2'd0) d.mode = mode_cfg_t'(wdata[4:0]);
        if (wr_en && addr == 2'd1) d.tcfg = time_cfg_t'(wdata);
        if (wr_en && addr == 2'd3 && wdata[5]) d.ovr = 1'b0;
        if (ovr_set) d.ovr = 1'b1;
        case (addr)
            2'd0:    rdata = {11'd0, q.mode};
            2'd1:    rdata = q.tcfg;
            2'd2:    rdata = rx_head;
            default: rdata = {10'd0, q.ovr, rx_empty, rx_full, tx_empty, tx_full, busy};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_port_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata), .pop(tx_pop),
        .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_port_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word), .pop(rx_pop),
        .dout(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spi_port_engine u_eng (
        .clk(clk), .rst_n(rst_n), .mode(q.mode), .tcfg(q.tcfg),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_word),
        .ovr_set(ovr_set), .busy(busy),
        .sck_o(sck_o), .ssn_o(ssn_o), .sdo(sdo),
        .sck_i(sck_i), .ssn_i(ssn_i), .sdi(sdi)
    );

    // R11
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(rx_full));

endmodule

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        sck_o, ssn_o, sdo;
    logic        sck_i = 1'b0, ssn_i = 1'b1, b_sdi = 1'b0, loop = 1'b1;
    logic        sdi;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    int cyc = 0;

    assign sdi = loop ? sdo : b_sdi;
    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sck_o(sck_o), .ssn_o(ssn_o),
        .sck_i(sck_i), .ssn_i(ssn_i), .sdi(sdi), .sdo(sdo)
    );

    // master-side line monitor
    logic        b_cpol = 1'b0, b_cpha = 1'b0;
    logic        psck = 1'b0, pssn = 1'b1, first_pend = 1'b0, have_rise = 1'b0;
    logic [31:0] mbits = '0;
    int nedges = 0, t_fall = 0, t_first = 0, t_last = 0, t_rise = 0, gap_min = 0;

    always @(negedge clk) begin
        if (ssn_o != pssn) begin
            if (!ssn_o) begin
                if (have_rise && (cyc - t_rise) < gap_min) gap_min = cyc - t_rise;
                t_fall = cyc;
                first_pend = 1'b1;
            end else begin
                t_rise = cyc;
                have_rise = 1'b1;
            end
        end
        if (sck_o != psck && !ssn_o) begin
            if (first_pend) begin t_first = cyc; first_pend = 1'b0; end
            t_last = cyc;
            nedges++;
            if (sck_o == (b_cpol ^ ~b_cpha)) mbits = {mbits[30:0], sdo};
        end
        psck = sck_o;
        pssn = ssn_o;
    end

    task automatic mon_clear();
        nedges = 0; mbits = '0; have_rise = 1'b0; gap_min = 1000000;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; #1 v = rdata; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd3, s);
            if (!s[0] && s[2]) break;
        end
    endtask

    function automatic logic [15:0] rev(input logic [15:0] v, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = v[i];
        return r;
    endfunction

    // bench acts as master towards the slave port: 8-bit, CPOL=0, CPHA=0, MSB first
    task automatic slave_frame(input logic [7:0] to_dut, output logic [7:0] from_dut);
        from_dut = '0;
        @(negedge clk); ssn_i = 1'b0; b_sdi = to_dut[7];
        repeat (8) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            from_dut[i] = sdo;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
            if (i > 0) b_sdi = to_dut[i-1];
            repeat (8) @(negedge clk);
        end
        ssn_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] s;
        rd(2'd3, s);
        check(s == 16'h0014, "R2 status after reset", s, 16'h0014);
        check(ssn_o == 1'b1, "R2 ssn_o after reset", ssn_o, 1);
        check(sck_o == 1'b0, "R2 sck_o after reset", sck_o, 0);
        check(nedges == 0, "R1 no master clock in slave mode", nedges, 0);
    endtask

    task automatic t_master_mode0();
        logic [15:0] v;
        loop = 1'b1; b_cpol = 1'b0; b_cpha = 1'b0;
        wr(2'd1, 16'h0001);          // div=1, lead=lag=gap=0
        wr(2'd0, 16'h0001);          // master, mode 0, MSB first, 8-bit
        mon_clear();
        wr(2'd2, 16'h00A5);
        wait_idle();
        check(mbits[7:0] == 8'hA5, "R3 R4 MSB-first bits", mbits[7:0], 8'hA5);
        check(nedges == 16, "R5 8-bit edge count", nedges, 16);
        check(t_first - t_fall == 2, "R6 lead=0 is half period", t_first - t_fall, 2);
        check(t_rise - t_last == 2, "R7 lag=0 is half period", t_rise - t_last, 2);
        rd(2'd2, v);
        check(v == 16'h00A5, "R3 R5 loopback receive", v, 16'h00A5);
    endtask

    task automatic t_master_mode3_lsb16();
        logic [15:0] v;
        b_cpol = 1'b1; b_cpha = 1'b1;
        wr(2'd0, 16'h001F);          // master, CPOL=1, CPHA=1, LSB first, 16-bit
        repeat (3) @(negedge clk);
        check(sck_o == 1'b1, "R12 idle level CPOL=1", sck_o, 1);
        mon_clear();
        wr(2'd2, 16'h1234);
        wait_idle();
        check(mbits[15:0] == rev(16'h1234, 16), "R4 LSB-first bits", mbits[15:0], rev(16'h1234, 16));
        check(nedges == 32, "R5 16-bit edge count", nedges, 32);
        rd(2'd2, v);
        check(v == 16'h1234, "R3 CPHA=1 loopback receive", v, 16'h1234);
    endtask

    task automatic t_master_timing();
        logic [15:0] v;
        b_cpol = 1'b0; b_cpha = 1'b0;
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h1532);          // div=2, lead=3, lag=2, gap=5
        mon_clear();
        wr(2'd2, 16'h0011);
        wr(2'd2, 16'h0022);
        wait_idle();
        check(t_first - t_fall == 18, "R6 lead delay", t_first - t_fall, 18);
        check(t_rise - t_last == 12, "R7 lag delay", t_rise - t_last, 12);
        check(gap_min >= 30, "R8 minimum gap", gap_min, 30);
        rd(2'd2, v);
        check(v == 16'h0011, "R3 first of two frames", v, 16'h0011);
        rd(2'd2, v);
        check(v == 16'h0022, "R3 second of two frames", v, 16'h0022);
    endtask

    task automatic t_slave_basic();
        logic [7:0]  got;
        logic [15:0] v;
        loop = 1'b0;
        wr(2'd0, 16'h0000);          // slave, mode 0, MSB first, 8-bit
        wr(2'd1, 16'h1FFF);          // timing fields must not matter
        wr(2'd2, 16'h003C);
        mon_clear();
        slave_frame(8'h96, got);
        check(got == 8'h3C, "R9 slave transmit", got, 8'h3C);
        rd(2'd2, v);
        check(v == 16'h0096, "R9 slave receive", v, 16'h0096);
        check(ssn_o == 1'b1, "R1 ssn_o idle in slave", ssn_o, 1);
        check(nedges == 0 && sck_o == 1'b0, "R1 sck_o quiet in slave", sck_o, 0);
    endtask

    task automatic t_fifo_overrun();
        logic [15:0] s, v;
        logic [7:0]  got;
        for (int i = 1; i <= 4; i++) wr(2'd2, 16'(i * 16'h11));
        rd(2'd3, s);
        check(s[1] == 1'b1 && s[2] == 1'b0, "R10 tx full flag", s, 16'h0002);
        wr(2'd2, 16'h00EE);          // dropped
        for (int i = 1; i <= 5; i++) begin
            slave_frame(8'(i), got);
            if (i == 4) check(got == 8'h44, "R10 fourth queued word", got, 8'h44);
            if (i == 5) check(got == 8'h00, "R10 R13 dropped write, zeros sent", got, 0);
        end
        rd(2'd3, s);
        check(s[5] == 1'b1 && s[3] == 1'b1, "R11 overrun flag set", s, 16'h0028);
        for (int i = 1; i <= 4; i++) begin
            rd(2'd2, v);
            check(v == 16'(i), "R11 rx words kept in order", v, i);
        end
        wr(2'd3, 16'h0020);
        rd(2'd3, s);
        check(s[5] == 1'b0 && s[4] == 1'b1, "R11 overrun cleared", s, 16'h0014);
    endtask

    initial begin
        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_master_mode0();
        t_master_mode3_lsb16();
        t_master_timing();
        t_slave_basic();
        t_fifo_overrun();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule